// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a configuration bitstream into a daisy chain of SRAM-based programmable devices over a two-wire serial link, a configuration clock and a data line. When `start` is seen, it pulses the shared active-low program line one or more times, each pulse a fixed number of system cycles long. It then waits for the wire-ORed init-ready line and shifts the bitstream out most significant bit first. The bitstream arrives as bytes over a ready/valid handshake. For a chain of identical devices, the stream carries one copy of the per-device image for each device, back to back.

After the last data bit the loader gives a few extra clock pulses. It then watches the wire-ORed done line for a bounded number of cycles. If done does not rise in that window, the loader repeats the whole load, program pulses included, and counts the retry. Once the retry budget is spent it stops with a final-failure flag. The configuration clock rests high whenever no bit is being shifted. Its low phase is always exactly one divider period, so the clock can never sit low longer than the dynamic configuration logic of the targets allows.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset `cfg_clk` and `cfg_prog_n` are 1; `busy`, `done_ok`, `fail_final`, `byte_ready` and `retry_cnt` are 0.
- R2: `start` in an idle state, including after success or final failure, begins a load. `cfg_prog_n` goes low for RST_CYCLES cycles, then high for RST_CYCLES cycles. This pair repeats `rst_repeats` times, and a value of 0 counts as 1. `cfg_clk` stays high while `cfg_prog_n` is low.
- R3: After the last program pulse, no byte is accepted and `cfg_clk` never goes low while `cfg_init` is 0.
- R4: `cfg_clk` rests high. Each low phase lasts exactly CLK_DIV cycles, and each high phase lasts at least CLK_DIV cycles. `cfg_data` changes only on the cycle `cfg_clk` falls, so it is stable across each rising edge.
- R5: Each attempt accepts exactly DEV_BYTES*N_DEV bytes. Byte bits go out most significant first, one bit per rising edge of `cfg_clk`, so there are eight rising edges per byte. Every attempt of a load sends the same bytes, and the bench repeats the per-device image N_DEV times.
- R6: If no valid byte is offered when one is due, `cfg_clk` holds high until one arrives. No low phase exceeds CLK_DIV cycles. CLK_DIV must lie between 1 and the number of system cycles in 5 µs, and this range is checked at elaboration.
- R7: After the last data bit, exactly EXTRA_CLKS further rising edges are produced. The total per attempt is 8*DEV_BYTES*N_DEV+EXTRA_CLKS.
- R8: `cfg_done` is sampled for DONE_TIMEOUT cycles, starting CLK_DIV+1 cycles after the last extra rising edge. A high sample ends the load with `done_ok`=1 and `busy`=0. A sample in the last cycle of the window still counts.
- R9: If the window closes without `cfg_done`, `retry_cnt` increments and the load restarts from the program pulses with the same repeat count.
- R10: If the window closes with `retry_cnt` equal to MAX_RETRIES, the loader stops with `fail_final`=1, `busy`=0, and `retry_cnt` left at MAX_RETRIES.
- R11: `start` and `rst_repeats` are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load when idle |
| rst_repeats | input | REP_W | Number of program pulses per attempt (0 treated as 1) |
| byte_data | input | 8 | Bitstream byte |
| byte_valid | input | 1 | Byte is offered |
| byte_ready | output | 1 | Byte is taken this cycle when valid |
| cfg_clk | output | 1 | Configuration clock, rests high |
| cfg_data | output | 1 | Serial configuration data |
| cfg_prog_n | output | 1 | Active-low program/reset to the targets |
| cfg_init | input | 1 | Wire-ORed init-ready line, high when targets can accept data |
| cfg_done | input | 1 | Wire-ORed done line |
| busy | output | 1 | A load is in progress |
| done_ok | output | 1 | Last load completed successfully |
| fail_final | output | 1 | Last load failed after all retries |
| retry_cnt | output | RETRY_W | Retries used in the current or last load |

## Verification
The critical collision is `cfg_done` arriving in the same cycle as the done-window timeout expiring. The bench times the arrival against the last extra clock edge. It raises done so that it is first sampled in the final cycle of the window, which must give success. In another attempt it raises done one cycle later, which must give a retry with a fresh program pulse. A second overlap is a `start` pulse in the middle of a load, with a different repeat count; the bench judges it by the unchanged number of program pulses and the normal completion.

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int SYS_CLK_HZ   = 250_000_000,
  parameter int CLK_DIV      = 4,
  parameter int RST_CYCLES   = 2_500_000,
  parameter int DEV_BYTES    = 16,
  parameter int N_DEV        = 2,
  parameter int EXTRA_CLKS   = 8,
  parameter int DONE_TIMEOUT = 1000,
  parameter int MAX_RETRIES  = 3,
  parameter int REP_W        = 8,
  parameter int RETRY_W      = $clog2(MAX_RETRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [REP_W-1:0]   rst_repeats,
  input  logic [7:0]         byte_data,
  input  logic               byte_valid,
  output logic               byte_ready,
  output logic               cfg_clk,
  output logic               cfg_data,
  output logic               cfg_prog_n,
  input  logic               cfg_init,
  input  logic               cfg_done,
  output logic               busy,
  output logic               done_ok,
  output logic               fail_final,
  output logic [RETRY_W-1:0] retry_cnt
);
  localparam int STREAM_BYTES = DEV_BYTES * N_DEV;
  localparam int LOW_LIMIT    = SYS_CLK_HZ / 200_000;
  localparam int TMR_MAX      = (RST_CYCLES > DONE_TIMEOUT) ? RST_CYCLES : DONE_TIMEOUT;
  localparam int TMR_W        = $clog2(TMR_MAX + 1);
  localparam int DIV_W        = $clog2(CLK_DIV + 1);
  localparam int BYTE_W       = $clog2(STREAM_BYTES + 1);
  localparam int EXTRA_W      = $clog2(EXTRA_CLKS + 2);

  if (CLK_DIV < 1 || CLK_DIV > LOW_LIMIT) begin : g_div_range
    initial $fatal(1, "cfg_serial_loader: CLK_DIV must be 1..%0d", LOW_LIMIT);
  end

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_GAP, S_WINIT, S_SHIFT, S_EXTRA, S_WDONE, S_OK, S_FAIL
  } state_t;

  state_t             st;
  logic [REP_W-1:0]   reps_q, reps_left;
  logic [TMR_W-1:0]   tmr;
  logic [DIV_W-1:0]   div;
  logic [7:0]         sr;
  logic [3:0]         bits_left;
  logic [BYTE_W-1:0]  bytes_left;
  logic [EXTRA_W-1:0] extra_left;

  wire phase_end = (div == '0);
  wire tmr_end   = (tmr == '0);
  wire idle_like = (st == S_IDLE) || (st == S_OK) || (st == S_FAIL);

  assign byte_ready = (st == S_SHIFT) && cfg_clk && phase_end &&
                      (bits_left == '0) && (bytes_left != '0);
  assign busy       = !idle_like;
  assign done_ok    = (st == S_OK);
  assign fail_final = (st == S_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cfg_clk    <= 1'b1;
      cfg_data   <= 1'b1;
      cfg_prog_n <= 1'b1;
      reps_q     <= '0;
      reps_left  <= '0;
      tmr        <= '0;
      div        <= '0;
      sr         <= '0;
      bits_left  <= '0;
      bytes_left <= '0;
      extra_left <= '0;
      retry_cnt  <= '0;
    end else begin
      case (st)
        S_IDLE, S_OK, S_FAIL: if (start) begin
          reps_q     <= (rst_repeats == '0) ? REP_W'(1) : rst_repeats;
          reps_left  <= (rst_repeats == '0) ? REP_W'(1) : rst_repeats;
          retry_cnt  <= '0;
          cfg_prog_n <= 1'b0;
          tmr        <= TMR_W'(RST_CYCLES - 1);
          st         <= S_PROG;
        end
        S_PROG: if (tmr_end) begin
          cfg_prog_n <= 1'b1;
          reps_left  <= reps_left - 1'b1;
          tmr        <= TMR_W'(RST_CYCLES - 1);
          st         <= S_GAP;
        end else tmr <= tmr - 1'b1;
        S_GAP: if (tmr_end) begin
          if (reps_left != '0) begin
            cfg_prog_n <= 1'b0;
            tmr        <= TMR_W'(RST_CYCLES - 1);
            st         <= S_PROG;
          end else st <= S_WINIT;
        end else tmr <= tmr - 1'b1;
        S_WINIT: if (cfg_init) begin
          bytes_left <= BYTE_W'(STREAM_BYTES);
          bits_left  <= '0;
          div        <= '0;
          st         <= S_SHIFT;
        end
        S_SHIFT, S_EXTRA: begin
          if (!cfg_clk) begin
            if (phase_end) begin
              cfg_clk <= 1'b1;
              div     <= DIV_W'(CLK_DIV - 1);
            end else div <= div - 1'b1;
          end else if (!phase_end) begin
            div <= div - 1'b1;
          end else if (st == S_SHIFT) begin
            if (bits_left != '0) begin
              cfg_data  <= sr[7];
              sr        <= {sr[6:0], 1'b0};
              bits_left <= bits_left - 1'b1;
              cfg_clk   <= 1'b0;
              div       <= DIV_W'(CLK_DIV - 1);
            end else if (bytes_left != '0) begin
              if (byte_valid) begin
                cfg_data   <= byte_data[7];
                sr         <= {byte_data[6:0], 1'b0};
                bits_left  <= 4'd7;
                bytes_left <= bytes_left - 1'b1;
                cfg_clk    <= 1'b0;
                div        <= DIV_W'(CLK_DIV - 1);
              end
            end else begin
              extra_left <= EXTRA_W'(EXTRA_CLKS);
              st         <= S_EXTRA;
            end
          end else if (extra_left != '0) begin
            extra_left <= extra_left - 1'b1;
            cfg_clk    <= 1'b0;
            div        <= DIV_W'(CLK_DIV - 1);
          end else begin
            tmr <= TMR_W'(DONE_TIMEOUT - 1);
            st  <= S_WDONE;
          end
        end
        S_WDONE: if (cfg_done) begin
          st <= S_OK;
        end else if (tmr_end) begin
          if (retry_cnt == RETRY_W'(MAX_RETRIES)) st <= S_FAIL;
          else begin
            retry_cnt  <= retry_cnt + 1'b1;
            reps_left  <= reps_q;
            cfg_prog_n <= 1'b0;
            tmr        <= TMR_W'(RST_CYCLES - 1);
            st         <= S_PROG;
          end
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [DIV_W:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else        low_run <= cfg_clk ? '0 : low_run + 1'b1;
  end

  assert_clk_low_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clk |-> int'(low_run) < CLK_DIV);

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_data));

  assert_prog_clk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> cfg_clk);

  assert_wait_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WINIT && !cfg_init) |=> (cfg_clk && !byte_ready));

  assert_ok_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_ok) |-> $past(cfg_done));

  assert_retry_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_cnt != $past(retry_cnt)) |-> !cfg_prog_n);

  assert_retry_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retry_cnt) <= MAX_RETRIES);
endmodule

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;
  localparam int CLK_DIV      = 2;
  localparam int RST_CYCLES   = 20;
  localparam int DEV_BYTES    = 3;
  localparam int N_DEV        = 2;
  localparam int EXTRA_CLKS   = 3;
  localparam int DONE_TIMEOUT = 40;
  localparam int MAX_RETRIES  = 2;
  localparam int RW           = $clog2(MAX_RETRIES + 1);
  localparam int NB           = DEV_BYTES * N_DEV;
  localparam int NRISE        = 8 * NB + EXTRA_CLKS;
  localparam int LAST_OK      = CLK_DIV + DONE_TIMEOUT - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] rst_repeats = '0, byte_data = '0;
  logic byte_valid = 1'b0, cfg_init = 1'b0, cfg_done = 1'b0;
  logic byte_ready, cfg_clk, cfg_data, cfg_prog_n, busy, done_ok, fail_final;
  logic [RW-1:0] retry_cnt;

  always #2 clk = ~clk;

  cfg_serial_loader #(
    .SYS_CLK_HZ(250_000_000), .CLK_DIV(CLK_DIV), .RST_CYCLES(RST_CYCLES),
    .DEV_BYTES(DEV_BYTES), .N_DEV(N_DEV), .EXTRA_CLKS(EXTRA_CLKS),
    .DONE_TIMEOUT(DONE_TIMEOUT), .MAX_RETRIES(MAX_RETRIES), .REP_W(8), .RETRY_W(RW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rst_repeats(rst_repeats),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data), .cfg_prog_n(cfg_prog_n),
    .cfg_init(cfg_init), .cfg_done(cfg_done), .busy(busy), .done_ok(done_ok),
    .fail_final(fail_final), .retry_cnt(retry_cnt)
  );

  int total = 0, bad = 0;
  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [7:0] exp_b [NB];
  int tgt [MAX_RETRIES+1];
  int init_lag = 10, valid_pct = 75;

  int prog_low = 0, prog_high = 0, n_pulses = 0, bad_plen = 0, bad_gap = 0;
  int rise_cnt = 0, bits_cap = 0, byte_pos = 0, bytes_ok = 0, bytes_bad = 0;
  int bad_rise = 0, bad_lowph = 0, low_run = 0, low_over = 0, data_err = 0;
  int init_err = 0, att = 0, dcnt = 0, itimer = 10, src = 0;
  bit had_pulse = 0, armed = 0, hs = 0, prev_clk = 1, prev_data = 1;
  logic [7:0] cap = '0;

  // target model and protocol monitor, evaluated away from the active edge
  always @(negedge clk) if (rst_n) begin
    if (!cfg_prog_n) begin
      if (prog_low == 0) begin
        if (had_pulse && rise_cnt == 0 && prog_high != RST_CYCLES) bad_gap++;
        if (rise_cnt != 0 && rise_cnt != NRISE) bad_rise++;
        if (rise_cnt != 0) att++;
        rise_cnt = 0; byte_pos = 0; bits_cap = 0; armed = 0;
      end
      prog_low++; prog_high = 0; cfg_done = 1'b0; cfg_init = 1'b0; itimer = init_lag;
    end else begin
      if (prog_low != 0) begin
        n_pulses++; had_pulse = 1;
        if (prog_low != RST_CYCLES) bad_plen++;
        prog_low = 0;
      end
      prog_high++;
      if (itimer > 0) itimer--; else cfg_init = 1'b1;
    end
    if (cfg_clk && prev_clk && cfg_data != prev_data) data_err++;
    if (!cfg_clk) begin
      low_run++;
      if (low_run > CLK_DIV) low_over++;
      if (!cfg_init) init_err++;
    end else begin
      if (!prev_clk) begin
        if (low_run != CLK_DIV) bad_lowph++;
        rise_cnt++;
        if (rise_cnt <= 8 * NB) begin
          cap = {cap[6:0], cfg_data};
          bits_cap++;
          if (bits_cap == 8) begin
            if (cap == exp_b[byte_pos]) bytes_ok++; else bytes_bad++;
            byte_pos++; bits_cap = 0;
          end
        end
        if (rise_cnt == NRISE) begin armed = 1; dcnt = 0; end
      end
      low_run = 0;
    end
    if (byte_ready && !cfg_init) init_err++;
    if (armed) begin
      if (att <= MAX_RETRIES && tgt[att] >= 0 && dcnt == tgt[att]) cfg_done = 1'b1;
      dcnt++;
    end
    hs = byte_valid && byte_ready;
    prev_clk = cfg_clk; prev_data = cfg_data;
  end

  // byte source: random gaps in valid, restarts with every program pulse
  always @(posedge clk) begin
    #1;
    if (!cfg_prog_n) begin
      src = 0; byte_valid = 1'b0;
    end else begin
      if (hs) begin src++; byte_valid = 1'b0; end
      if (!byte_valid && src < NB && int'($urandom % 100) < valid_pct) begin
        byte_valid = 1'b1; byte_data = exp_b[src];
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int first_ok();
    for (int i = 0; i <= MAX_RETRIES; i++)
      if (tgt[i] >= 0 && tgt[i] <= LAST_OK) return i;
    return -1;
  endfunction

  task automatic run_load(int reps, int t0, int t1, int t2, int lag, int pct, bit poke);
    int idx, attempts, eff;
    tgt[0] = t0; tgt[1] = t1; tgt[2] = t2;
    for (int k = 0; k < DEV_BYTES; k++) begin
      automatic logic [7:0] v = 8'($urandom);
      for (int n = 0; n < N_DEV; n++) exp_b[n * DEV_BYTES + k] = v;
    end
    n_pulses = 0; bad_plen = 0; bad_gap = 0; had_pulse = 0; rise_cnt = 0;
    bytes_ok = 0; bytes_bad = 0; bad_rise = 0; bad_lowph = 0; low_over = 0;
    data_err = 0; init_err = 0; att = 0; armed = 0;
    init_lag = lag; valid_pct = pct;
    @(posedge clk); #1; rst_repeats = 8'(reps); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    if (poke) begin
      repeat (150) @(posedge clk);
      #1; start = 1'b1; rst_repeats = 8'd7;
      @(posedge clk); #1; start = 1'b0;
    end
    do @(negedge clk); while (busy);
    idx = first_ok();
    attempts = (idx >= 0) ? idx + 1 : MAX_RETRIES + 1;
    eff = (reps == 0) ? 1 : reps;
    chk("R8 done_ok", done_ok, idx >= 0);
    chk("R10 fail_final", fail_final, idx < 0);
    chk("R9 retry_cnt", retry_cnt, (idx >= 0) ? idx : MAX_RETRIES);
    chk("R2 program pulse count", n_pulses, attempts * eff);
    chk("R2 program pulse length errors", bad_plen, 0);
    chk("R2 program gap errors", bad_gap, 0);
    chk("R5 bytes matched", bytes_ok, attempts * NB);
    chk("R5 byte mismatches", bytes_bad, 0);
    chk("R7 rising edges last attempt", rise_cnt, NRISE);
    chk("R7 rising edge count errors", bad_rise, 0);
    chk("R4 data change while high", data_err, 0);
    chk("R4 low phase length errors", bad_lowph, 0);
    chk("R4 clock rests high", cfg_clk, 1);
    chk("R6 low phase overruns", low_over, 0);
    chk("R3 activity before init", init_err, 0);
    if (poke) chk("R11 start while busy ignored", n_pulses, attempts * eff);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 cfg_clk", cfg_clk, 1);
    chk("R1 cfg_prog_n", cfg_prog_n, 1);
    chk("R1 busy", busy, 0);
    chk("R1 done_ok", done_ok, 0);
    chk("R1 fail_final", fail_final, 0);
    chk("R1 byte_ready", byte_ready, 0);
    chk("R1 retry_cnt", retry_cnt, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 still idle", busy, 0);
    run_load(3, 30, -1, -1, 10, 75, 0);
    run_load(0, LAST_OK + 1, LAST_OK, -1, 10, 75, 0);
    run_load(1, -1, -1, -1, 10, 75, 0);
    run_load(2, 0, -1, -1, 80, 20, 1);
    for (int r = 0; r < 5; r++)
      run_load(1 + int'($urandom % 3), int'($urandom % 60) - 10,
               int'($urandom % 60) - 10, int'($urandom % 45),
               1 + int'($urandom % 50), 30 + int'($urandom % 70), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule